// File: doc/BRIEF.md
# Seat Belt Reminder Alarm Controller

This block watches the ignition key and the belt buckle of a vehicle seat and raises an alarm level when the driver turns the key on but leaves the belt open too long. A control machine with three states (idle, grace, sounding) runs in lock-step with a small seconds timer. The timer is stepped by a one-cycle seconds pulse that comes from elsewhere in the chip. Both the timer and the control machine update on the same clock edge, so a seconds pulse and a key or belt event in the same cycle are resolved together as one combined step.

After key-on the timer restarts at zero. If the belt is fastened or the key is turned off before the fifth seconds pulse, the controller goes back to idle and stays silent. On the fifth pulse it starts sounding. The alarm stops on the tenth pulse counted from key-on, or earlier when the belt is fastened or the key is turned off. Key and belt events win over a timer event that falls in the same cycle. The alarm output is registered, so it changes only on the clock edge that follows the cause.

Top module: `belt_alarm_ctrl`

## Requirements
- R1: While `rst_n` is sampled low the controller goes to idle and `alarm` reads 0 after the next edge. Seconds pulses seen in idle, with no key-on, never raise `alarm`.
- R2: In idle, a cycle with `key_on` high enters the grace state and sets the timer to 0. A seconds pulse in that same cycle is not counted.
- R3: In the grace state, `key_off` or `belt_on` returns the controller to idle and `alarm` stays 0.
- R4: In the grace state, the seconds pulse that brings the timer to GRACE_SECS (default 5) sets `alarm` to 1 after that edge.
- R5: While sounding, the seconds pulse that brings the timer to LIMIT_SECS (default 10) clears `alarm` and returns the controller to idle.
- R6: While sounding, `belt_on` or `key_off` clears `alarm` after the next edge and returns the controller to idle.
- R7: When `key_off` or `belt_on` falls in the same cycle as the pulse that reaches GRACE_SECS or LIMIT_SECS, the controller goes to idle and `alarm` reads 0.
- R8: In the grace and sounding states, `key_on` has no effect: it does not restart the timer.
- R9: The timer does not count in idle. It counts one step per seconds pulse outside idle and never goes above LIMIT_SECS.
- R10: `alarm` is a registered output. It changes only at a rising clock edge and never in the same cycle as the input that causes the change.
- R11: With no key or belt events after key-on, `alarm` stays high for exactly LIMIT_SECS minus GRACE_SECS seconds pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| key_on | input | 1 | One-cycle event: ignition key turned on |
| key_off | input | 1 | One-cycle event: ignition key turned off |
| belt_on | input | 1 | One-cycle event: seat belt fastened |
| sec_tick | input | 1 | One-cycle seconds pulse |
| alarm | output | 1 | Alarm level, high while sounding |

## Verification
The bench targets the edges of the two timeouts. It checks the fourth pulse against the fifth, so a timer that is off by one starts the alarm one second early or late. It sends a belt or key event in the same cycle as the fifth or tenth pulse; a design with the wrong priority would sound the alarm or hold it for one more cycle. It sends a seconds pulse together with key-on, and key-on again during the grace period; a timer that counts in idle or restarts on a repeated key-on would move the alarm onset. It also checks `alarm` just before the clock edge, which catches a combinational output.

// File: rtl/belt_alarm_pkg.sv
// Package: shared state encoding for the seat belt alarm controller.
// Assumes: nothing outside this package depends on the numeric codes.
package belt_alarm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GRACE = 2'd1,
        ST_SOUND = 2'd2
    } belt_state_t;

endpackage

// File: rtl/belt_sec_timer.sv
// Module: seconds timer that steps in lock-step with the control machine.
// What it does: counts seconds pulses from 0 up to LIMIT_SECS while run is
//   high, saturating at LIMIT_SECS; restart clears it to 0 and wins over a
//   pulse in the same cycle. It flags, combinationally, the pulse that will
//   bring the count to GRACE_SECS or to LIMIT_SECS at the coming edge.
// Assumes: sec_tick is a single-cycle pulse synchronous to clk.
module belt_sec_timer #(
    parameter int GRACE_SECS = 5,
    parameter int LIMIT_SECS = 10,
    parameter int CNT_W      = $clog2(LIMIT_SECS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic             sec_tick,
    output logic [CNT_W-1:0] secs_q,
    output logic             grace_evt,
    output logic             limit_evt
);

    localparam logic [CNT_W-1:0] GRACE_PRE = CNT_W'(GRACE_SECS - 1);
    localparam logic [CNT_W-1:0] LIMIT_PRE = CNT_W'(LIMIT_SECS - 1);
    localparam logic [CNT_W-1:0] LIMIT_VAL = CNT_W'(LIMIT_SECS);

    logic step;

    // Purpose: a counting step happens on a pulse while running, below the cap.
    always_comb begin
        step = run && sec_tick && (secs_q != LIMIT_VAL);
    end

    // Purpose: timeout events describe the value the counter reaches this edge.
    always_comb begin
        grace_evt = step && (secs_q == GRACE_PRE);
        limit_evt = step && (secs_q == LIMIT_PRE);
    end

    // Purpose: the counter register itself.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            secs_q <= '0;
        end else if (restart) begin
            secs_q <= '0;
        end else if (step) begin
            secs_q <= secs_q + 1'b1;
        end
    end

endmodule

// File: rtl/belt_ctrl_fsm.sv
// Module: control machine of the seat belt alarm.
// What it does: moves between idle, grace and sounding on key, belt and
//   timer events; key and belt events win over timer events in one cycle.
//   It drives the timer's restart and run controls and a registered alarm.
// Assumes: the timer events refer to the same edge at which this machine
//   updates, so both halves form one synchronous product machine.
module belt_ctrl_fsm
    import belt_alarm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        key_on,
    input  logic        key_off,
    input  logic        belt_on,
    input  logic        grace_evt,
    input  logic        limit_evt,
    output belt_state_t state_q,
    output logic        restart,
    output logic        run,
    output logic        alarm_q
);

    belt_state_t state_d;
    logic        quit_evt;

    // Purpose: a driver action that ends both grace and sounding.
    always_comb begin
        quit_evt = key_off || belt_on;
    end

    // Purpose: timer controls follow the current state.
    always_comb begin
        restart = (state_q == ST_IDLE) && key_on;
        run     = (state_q != ST_IDLE);
    end

    // Purpose: next-state rules; unlisted conditions keep the state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (key_on) state_d = ST_GRACE;
            end
            ST_GRACE: begin
                if (quit_evt)       state_d = ST_IDLE;
                else if (grace_evt) state_d = ST_SOUND;
            end
            ST_SOUND: begin
                if (quit_evt || limit_evt) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Purpose: state and alarm registers, updated together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            alarm_q <= 1'b0;
        end else begin
            state_q <= state_d;
            alarm_q <= (state_d == ST_SOUND);
        end
    end

endmodule

// File: rtl/belt_alarm_ctrl.sv
// Module: top of the seat belt reminder alarm controller.
// What it does: joins the control machine and the seconds timer so that
//   both change state on the same edge, and exposes the alarm level.
// Assumes: key_on, key_off, belt_on and sec_tick are clean one-cycle pulses
//   synchronous to clk; 0 < GRACE_SECS < LIMIT_SECS.
module belt_alarm_ctrl #(
    parameter int GRACE_SECS = 5,
    parameter int LIMIT_SECS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic key_on,
    input  logic key_off,
    input  logic belt_on,
    input  logic sec_tick,
    output logic alarm
);
    import belt_alarm_pkg::*;

    localparam int CNT_W = $clog2(LIMIT_SECS + 1);

    belt_state_t      state_q;
    logic [CNT_W-1:0] secs_q;
    logic             restart;
    logic             run;
    logic             grace_evt;
    logic             limit_evt;
    logic             alarm_q;

    belt_sec_timer #(
        .GRACE_SECS (GRACE_SECS),
        .LIMIT_SECS (LIMIT_SECS),
        .CNT_W      (CNT_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .run       (run),
        .sec_tick  (sec_tick),
        .secs_q    (secs_q),
        .grace_evt (grace_evt),
        .limit_evt (limit_evt)
    );

    belt_ctrl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_on    (key_on),
        .key_off   (key_off),
        .belt_on   (belt_on),
        .grace_evt (grace_evt),
        .limit_evt (limit_evt),
        .state_q   (state_q),
        .restart   (restart),
        .run       (run),
        .alarm_q   (alarm_q)
    );

    // Purpose: the registered alarm goes straight to the port.
    always_comb begin
        alarm = alarm_q;
    end

endmodule

// File: rtl/belt_alarm_chk.sv
// Module: property checker for belt_alarm_ctrl, bound to every instance.
// What it does: watches ports and the state and timer registers over time.
// Assumes: synchronous active-low reset, as in the design.
module belt_alarm_chk
    import belt_alarm_pkg::*;
#(
    parameter int GRACE_SECS = 5,
    parameter int LIMIT_SECS = 10,
    parameter int CNT_W      = $clog2(LIMIT_SECS + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             key_on,
    input logic             key_off,
    input logic             belt_on,
    input logic             sec_tick,
    input logic             alarm,
    input belt_state_t      state_q,
    input logic [CNT_W-1:0] secs_q
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !alarm);

    // R2
    start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && key_on) |=> (state_q == ST_GRACE && secs_q == '0));

    // R3
    grace_quit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!alarm && (key_off || belt_on)) |=> !alarm);

    // R6
    sound_quit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm && (key_off || belt_on)) |=> (!alarm && state_q == ST_IDLE));

    // R8
    rekey_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && !sec_tick) |=> $stable(secs_q));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !key_on) |=> $stable(secs_q));

    // R9
    timer_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        secs_q <= CNT_W'(LIMIT_SECS));

    // R4
    onset_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(alarm)) |-> ($past(sec_tick) && secs_q == CNT_W'(GRACE_SECS)));

    // R5
    stop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(alarm)) |-> $past(sec_tick || key_off || belt_on));

endmodule

bind belt_alarm_ctrl belt_alarm_chk #(
    .GRACE_SECS (GRACE_SECS),
    .LIMIT_SECS (LIMIT_SECS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_on   (key_on),
    .key_off  (key_off),
    .belt_on  (belt_on),
    .sec_tick (sec_tick),
    .alarm    (alarm),
    .state_q  (state_q),
    .secs_q   (secs_q)
);

// File: tb/belt_alarm_ctrl_tb.sv
`timescale 1ns/1ps
module belt_alarm_ctrl_tb;

    localparam int GRACE = 5;
    localparam int LIMIT = 10;
    localparam int NVEC  = 46;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic key_on = 1'b0, key_off = 1'b0, belt_on = 1'b0, sec_tick = 1'b0;
    logic alarm;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    belt_alarm_ctrl #(.GRACE_SECS(GRACE), .LIMIT_SECS(LIMIT)) u_dut (
        .clk(clk), .rst_n(rst_n), .key_on(key_on), .key_off(key_off),
        .belt_on(belt_on), .sec_tick(sec_tick), .alarm(alarm)
    );

    always #4 clk = ~clk;

    // Vector fields: [8:5] requirement number, [4] key_on, [3] key_off,
    // [2] belt_on, [1] sec_tick, [0] expected alarm after the edge.
    localparam logic [8:0] VEC [NVEC] = '{
        {4'd9, 5'b0001_0},  // R9 pulse in idle, no effect
        {4'd2, 5'b1001_0},  // R2 key_on with pulse: pulse not counted
        {4'd2, 5'b0001_0}, {4'd2, 5'b0001_0}, {4'd2, 5'b0001_0}, {4'd2, 5'b0001_0}, // secs 4
        {4'd8, 5'b1000_0},  // R8 key_on in grace ignored
        {4'd4, 5'b0001_1},  // R4 fifth pulse starts alarm
        {4'd11,5'b0000_1},
        {4'd11,5'b0001_1}, {4'd11,5'b0001_1}, {4'd11,5'b0001_1}, {4'd11,5'b0001_1}, // secs 9
        {4'd5, 5'b0001_0},  // R5 tenth pulse stops alarm
        {4'd9, 5'b0001_0},  // R9 idle again
        {4'd2, 5'b1000_0},
        {4'd2, 5'b0001_0}, {4'd2, 5'b0001_0}, {4'd2, 5'b0001_0}, {4'd2, 5'b0001_0},
        {4'd7, 5'b0011_0},  // R7 belt with fifth pulse wins
        {4'd2, 5'b1000_0},
        {4'd2, 5'b0001_0}, {4'd2, 5'b0001_0}, {4'd2, 5'b0001_0}, {4'd2, 5'b0001_0},
        {4'd4, 5'b0001_1},
        {4'd6, 5'b0010_0},  // R6 belt stops alarm
        {4'd2, 5'b1000_0},
        {4'd3, 5'b0100_0},  // R3 key_off in grace
        {4'd3, 5'b0001_0}, {4'd3, 5'b0001_0}, {4'd3, 5'b0001_0}, {4'd3, 5'b0001_0}, {4'd3, 5'b0001_0},
        {4'd2, 5'b1000_0},
        {4'd2, 5'b0001_0}, {4'd2, 5'b0001_0}, {4'd2, 5'b0001_0}, {4'd2, 5'b0001_0},
        {4'd4, 5'b0001_1},
        {4'd11,5'b0001_1}, {4'd11,5'b0001_1}, {4'd11,5'b0001_1}, {4'd11,5'b0001_1},
        {4'd7, 5'b0101_0}   // R7 key_off with tenth pulse wins
    };

    task automatic check(input int req, input logic exp, input string what);
        checks++;
        if (alarm !== exp) begin
            failures++;
            $display("FAIL R%0d %s: alarm=%b expected=%b", req, what, alarm, exp);
        end
    endtask

    // Drive one cycle of inputs at a falling edge, return at the next one.
    task automatic step(input logic kon, input logic koff, input logic belt, input logic tk);
        key_on = kon; key_off = koff; belt_on = belt; sec_tick = tk;
        @(negedge clk);
        key_on = 1'b0; key_off = 1'b0; belt_on = 1'b0; sec_tick = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog: run hung, done=%b expected=1", done);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int rise_at;
        int fall_at;
        int n;
        @(negedge clk);
        @(negedge clk);
        check(1, 1'b0, "alarm low in reset");   // R1
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][4], VEC[i][3], VEC[i][2], VEC[i][1]);
            check(int'(VEC[i][8:5]), VEC[i][0], $sformatf("vector %0d", i));
        end

        // R10: output must not follow an input before the edge.
        step(1'b1, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < GRACE - 1; i++) step(1'b0, 1'b0, 1'b0, 1'b1);
        sec_tick = 1'b1;
        #1;
        check(10, 1'b0, "alarm before edge of fifth pulse");
        @(negedge clk);
        sec_tick = 1'b0;
        check(10, 1'b1, "alarm after edge of fifth pulse");
        belt_on = 1'b1;
        #1;
        check(10, 1'b1, "alarm holds before edge of belt event");
        @(negedge clk);
        belt_on = 1'b0;
        check(6, 1'b0, "alarm cleared by belt");

        // R1: reset in the middle of sounding.
        step(1'b1, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < GRACE; i++) step(1'b0, 1'b0, 1'b0, 1'b1);
        check(4, 1'b1, "alarm before mid-run reset");
        rst_n = 1'b0;
        @(negedge clk);
        check(1, 1'b0, "alarm cleared by reset");
        rst_n = 1'b1;
        for (int i = 0; i < LIMIT; i++) step(1'b0, 1'b0, 1'b0, 1'b1);
        check(1, 1'b0, "no alarm after reset without key_on");

        // R11: count the pulses between alarm onset and end.
        step(1'b1, 1'b0, 1'b0, 1'b0);
        rise_at = -1;
        fall_at = -1;
        for (int i = 1; i <= LIMIT + 3; i++) begin
            step(1'b0, 1'b0, 1'b0, 1'b1);
            if (alarm && rise_at < 0) rise_at = i;
            if (!alarm && rise_at >= 0 && fall_at < 0) fall_at = i;
        end
        n = fall_at - rise_at;
        checks++;
        if (rise_at != GRACE || n != LIMIT - GRACE) begin
            failures++;
            $display("FAIL R11 alarm onset/length: onset=%0d length=%0d expected=%0d/%0d",
                     rise_at, n, GRACE, LIMIT - GRACE);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule